// File: doc/BRIEF.md
# Memory Training Data Pattern Generator

This block produces the 32-bit data word that a memory interface writes at each beat of a training burst. A caller selects a pattern type, gives a beat index and says whether the data bus is 32 or 16 bits wide. The combinational lookup port then returns that beat's word.

A start strobe runs a small sequencer. It captures the pattern type and the bus mode, steps the beat index from zero through a whole burst, and emits one registered word per cycle with a valid flag. After the last beat it raises a one-cycle done pulse.

The pattern families are:
- alternating 0x55/0xAA words
- read-levelling markers
- per-lane crosstalk words built from aggressor and victim bits
- simultaneous-switching toggles
- reference-voltage bitmaps
- a walking byte

The aggressor/victim bit columns and the reference-voltage bitmap are build-time parameters. Bit r of each vector is table row r.

Top module: `trn_pattern_gen`

## Requirements
- R1: In 32-bit mode (half_bus=0), types 0 and 1 give 0x55555555 at beats 0, 2, 5 and 7 and 0xAAAAAAAA at every other beat. Type 2 gives 0x55555555 at even beats and 0xAAAAAAAA at odd beats.
- R2: In 16-bit mode (half_bus=1), types 0, 1 and 2 give 0x55AA55AA at every beat. Type 5 gives 0x00FF00FF at every beat.
- R3: Types 3 and 4 give zero below a beat threshold: 6 in 32-bit mode and 3 in 16-bit mode. From the threshold on, type 3 gives 0x80808080 and type 4 gives 0x01010101.
- R4: Types 8 to 15 are crosstalk patterns aimed at lane d = type-8. In 32-bit mode, row r = beat mod 64 builds one byte. Bit d of that byte is the aggressor bit of row r, and every other bit is the victim bit of row r. The byte is copied into all four bytes of the word.
- R5: In 16-bit crosstalk mode, byte E is built the same way from row (2·beat) mod 64 and byte O from row (2·beat+1) mod 64. The word is {O,O,E,E}, so E fills bits 15:0.
- R6: In 32-bit mode, types 16 to 19 are switching patterns with selector s = type-16. The word is all zeros when floor(beat/(s+1)) is even and all ones when it is odd.
- R7: In 16-bit mode, type 16 gives 0x0000FFFF. Types 17 to 19 apply the R6 rule with selector type-17.
- R8: In 32-bit mode, type 6 gives all ones when bit (beat mod 64) of the reference bitmap is 1 and zero otherwise. In 16-bit mode, bits 31:16 repeat the victim bit of row (2·beat) mod 64 and bits 15:0 repeat the victim bit of row (2·beat+1) mod 64.
- R9: In 32-bit mode, type 5 copies bits 15:8 of (0xFF << floor(beat/3)) into all four bytes. This reaches zero from beat 48 on.
- R10: Type 7 and types 20 to 31 give zero.
- R11: The cycle after an accepted start, seq_valid is high for exactly BURST_LEN cycles. During those cycles seq_beat counts 0, 1, … and seq_word equals the lookup word for the type and mode captured at start.
- R12: seq_done is high for exactly one cycle, the cycle after the last valid beat, and never together with seq_valid.
- R13: A start, pat_sel or half_bus change during a burst does not change that burst and does not add beats.
- R14: After reset, seq_valid, seq_done and seq_word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_sel | input | 5 | Pattern type, used by the lookup and captured at start |
| half_bus | input | 1 | 1 selects 16-bit bus construction |
| beat_idx | input | BEAT_W | Beat index for the lookup port |
| word | output | 32 | Lookup word for pat_sel, half_bus, beat_idx |
| start | input | 1 | Starts a burst when idle |
| seq_valid | output | 1 | Burst beat valid |
| seq_beat | output | BEAT_W | Index of the current burst beat |
| seq_word | output | 32 | Word of the current burst beat |
| seq_done | output | 1 | One-cycle pulse after the last beat |

## Verification
The bench targets several corner cases, and each has a visible failure:
- **Lane choice.** It sweeps every crosstalk lane. A design that took the aggressor bit for the wrong lane would move the odd bit to another position.
- **16-bit half order.** A design that swapped the 16-bit halves would return {E,E,O,O}.
- **Thresholds.** It probes the read-levelling threshold on both sides in both modes. A threshold off by one would leak a marker into the quiet beats.
- **Wrap-around.** It uses beats high enough that 16-bit row addresses wrap. The walking byte is also expected to fall to zero near the end of the burst.
- **Burst isolation.** It restarts and changes the type in the middle of a burst. A design that re-captured would change words partway through or run long, and the scoreboard would see extra or wrong beats.

// File: rtl/trn_pat_pkg.sv
// Shared encodings and helper functions for the training pattern generator.
// Assumes 32-bit output words built from byte or half-word replication.
package trn_pat_pkg;

    localparam int SEL_W = 5;

    // Pattern type codes; lookup decode depends on these values.
    localparam logic [SEL_W-1:0] PS_ALT_A   = 5'd0;
    localparam logic [SEL_W-1:0] PS_ALT_B   = 5'd1;
    localparam logic [SEL_W-1:0] PS_ALT_PAR = 5'd2;
    localparam logic [SEL_W-1:0] PS_RL_HI   = 5'd3;
    localparam logic [SEL_W-1:0] PS_RL_LO   = 5'd4;
    localparam logic [SEL_W-1:0] PS_WALK    = 5'd5;
    localparam logic [SEL_W-1:0] PS_VREF    = 5'd6;

    localparam logic [31:0] W_55   = 32'h5555_5555;
    localparam logic [31:0] W_AA   = 32'hAAAA_AAAA;
    localparam logic [31:0] W_55AA = 32'h55AA_55AA;
    localparam logic [31:0] W_00FF = 32'h00FF_00FF;
    localparam logic [31:0] W_80   = 32'h8080_8080;
    localparam logic [31:0] W_01   = 32'h0101_0101;
    localparam logic [31:0] W_LOHALF = 32'h0000_FFFF;

    typedef enum logic [2:0] {
        FAM_ALT,
        FAM_RL,
        FAM_WALK,
        FAM_VREF,
        FAM_XT,
        FAM_SSO,
        FAM_NONE
    } pat_fam_e;

    // Map a pattern type code to its family.
    function automatic pat_fam_e fam_of(input logic [SEL_W-1:0] s);
        if (s <= PS_ALT_PAR)                       return FAM_ALT;
        else if (s == PS_RL_HI || s == PS_RL_LO)   return FAM_RL;
        else if (s == PS_WALK)                     return FAM_WALK;
        else if (s == PS_VREF)                     return FAM_VREF;
        else if (s[4:3] == 2'b01)                  return FAM_XT;
        else if (s[4:2] == 3'b100)                 return FAM_SSO;
        else                                       return FAM_NONE;
    endfunction

    // Copy one byte into all four byte lanes.
    function automatic logic [31:0] rep4(input logic [7:0] b);
        return {4{b}};
    endfunction

    // Spread one bit across the whole word.
    function automatic logic [31:0] fill(input logic b);
        return {32{b}};
    endfunction

    // Upper byte of 0xFF shifted left by k.
    function automatic logic [7:0] walk_byte(input logic [31:0] k);
        logic [31:0] t;
        t = 32'h0000_00FF << k;
        return t[15:8];
    endfunction

endpackage

// File: rtl/trn_word_lut.sv
// Combinational word lookup: pattern type, bus mode and beat index in,
// 32-bit training word out. Assumes the type codes of trn_pat_pkg and
// table vectors where bit r is row r.
module trn_word_lut
    import trn_pat_pkg::*;
#(
    parameter int          BEAT_W    = 6,
    parameter int          TBL_ROWS  = 64,
    parameter int          VREF_BITS = 64,
    parameter logic [63:0] AGG_COL   = 64'hA5C3_9E17_6B2D_F048,
    parameter logic [63:0] VIC_COL   = 64'h3C5A_0FF1_92E4_7DB6,
    parameter logic [63:0] VREF_MAP  = 64'hD349_A71E_65BC_28F1
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              half,
    input  logic [BEAT_W-1:0] idx,
    output logic [31:0]       word
);

    localparam int ROW_W  = $clog2(TBL_ROWS);
    localparam int VREF_W = $clog2(VREF_BITS);

    pat_fam_e          fam;
    logic [31:0]       idx_w;
    logic [31:0]       div3;
    logic [ROW_W-1:0]  row_a;
    logic [ROW_W-1:0]  row_e;
    logic [ROW_W-1:0]  row_o;
    logic [VREF_W-1:0] vref_pos;
    logic [2:0]        lane;
    logic [7:0]        xt_one;
    logic [7:0]        xt_even;
    logic [7:0]        xt_odd;
    logic [1:0]        sso_step;
    logic              sso_bit;

    // Index arithmetic shared by all families.
    assign fam      = fam_of(sel);
    assign idx_w    = 32'(idx);
    assign div3     = idx_w / 32'd3;
    assign row_a    = ROW_W'(idx_w % 32'(TBL_ROWS));
    assign row_e    = ROW_W'((idx_w * 32'd2) % 32'(TBL_ROWS));
    assign row_o    = ROW_W'((idx_w * 32'd2 + 32'd1) % 32'(TBL_ROWS));
    assign vref_pos = VREF_W'(idx_w % 32'(VREF_BITS));
    assign lane     = sel[2:0];

    // Per-lane crosstalk bits: the aimed lane takes aggressor, others victim.
    for (genvar i = 0; i < 8; i++) begin : g_lane
        assign xt_one[i]  = (lane == 3'(i)) ? AGG_COL[row_a] : VIC_COL[row_a];
        assign xt_even[i] = (lane == 3'(i)) ? AGG_COL[row_e] : VIC_COL[row_e];
        assign xt_odd[i]  = (lane == 3'(i)) ? AGG_COL[row_o] : VIC_COL[row_o];
    end

    // Switching toggle: parity of floor(idx/(step+1)).
    always_comb begin
        sso_step = half ? (sel[1:0] - 2'd1) : sel[1:0];
        case (sso_step)
            2'd0:    sso_bit = idx_w[0];
            2'd1:    sso_bit = idx_w[1];
            2'd2:    sso_bit = div3[0];
            default: sso_bit = idx_w[2];
        endcase
    end

    // Final word selection per family and bus mode.
    always_comb begin
        word = '0;
        case (fam)
            FAM_ALT: begin
                if (half)
                    word = W_55AA;
                else if (sel == PS_ALT_PAR)
                    word = idx_w[0] ? W_AA : W_55;
                else if (idx_w == 32'd0 || idx_w == 32'd2 ||
                         idx_w == 32'd5 || idx_w == 32'd7)
                    word = W_55;
                else
                    word = W_AA;
            end
            FAM_RL: begin
                if (idx_w < (half ? 32'd3 : 32'd6))
                    word = '0;
                else
                    word = (sel == PS_RL_HI) ? W_80 : W_01;
            end
            FAM_WALK: begin
                word = half ? W_00FF : rep4(walk_byte(div3));
            end
            FAM_VREF: begin
                if (half)
                    word = {{16{VIC_COL[row_e]}}, {16{VIC_COL[row_o]}}};
                else
                    word = fill(VREF_MAP[vref_pos]);
            end
            FAM_XT: begin
                word = half ? {xt_odd, xt_odd, xt_even, xt_even} : rep4(xt_one);
            end
            FAM_SSO: begin
                if (half && sel[1:0] == 2'd0)
                    word = W_LOHALF;
                else
                    word = fill(sso_bit);
            end
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/trn_burst_seq.sv
// Burst sequencer: on start while idle, captures type and mode and steps a
// beat counter from 0 to BURST_LEN-1, one beat per cycle.
// Assumes BURST_LEN >= 2; start while busy is ignored.
module trn_burst_seq
    import trn_pat_pkg::*;
#(
    parameter int BURST_LEN = 64,
    parameter int BEAT_W    = $clog2(BURST_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              half_in,
    output logic              busy,
    output logic [BEAT_W-1:0] cnt,
    output logic [SEL_W-1:0]  cap_sel,
    output logic              cap_half
);

    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

    // Capture on start and advance the beat counter until the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            cap_sel  <= '0;
            cap_half <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy     <= 1'b1;
                cnt      <= '0;
                cap_sel  <= sel_in;
                cap_half <= half_in;
            end
        end else if (cnt == LAST) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/trn_pattern_gen.sv
// Training data pattern generator top: a free lookup port plus a burst
// sequencer with registered outputs. Assumes synchronous active-low reset.
module trn_pattern_gen
    import trn_pat_pkg::*;
#(
    parameter int          BURST_LEN = 64,
    parameter int          TBL_ROWS  = 64,
    parameter int          VREF_BITS = 64,
    parameter logic [63:0] AGG_COL   = 64'hA5C3_9E17_6B2D_F048,
    parameter logic [63:0] VIC_COL   = 64'h3C5A_0FF1_92E4_7DB6,
    parameter logic [63:0] VREF_MAP  = 64'hD349_A71E_65BC_28F1,
    localparam int         BEAT_W    = $clog2(BURST_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        pat_sel,
    input  logic              half_bus,
    input  logic [BEAT_W-1:0] beat_idx,
    output logic [31:0]       word,
    input  logic              start,
    output logic              seq_valid,
    output logic [BEAT_W-1:0] seq_beat,
    output logic [31:0]       seq_word,
    output logic              seq_done
);

    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

    logic              busy;
    logic [BEAT_W-1:0] cnt;
    logic [SEL_W-1:0]  cap_sel;
    logic              cap_half;
    logic [31:0]       run_word;

    // Direct lookup path.
    trn_word_lut #(
        .BEAT_W(BEAT_W), .TBL_ROWS(TBL_ROWS), .VREF_BITS(VREF_BITS),
        .AGG_COL(AGG_COL), .VIC_COL(VIC_COL), .VREF_MAP(VREF_MAP)
    ) u_look_lut (
        .sel(pat_sel), .half(half_bus), .idx(beat_idx), .word(word)
    );

    trn_burst_seq #(.BURST_LEN(BURST_LEN), .BEAT_W(BEAT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sel_in(pat_sel), .half_in(half_bus),
        .busy(busy), .cnt(cnt), .cap_sel(cap_sel), .cap_half(cap_half)
    );

    // Burst path lookup on the captured type and mode.
    trn_word_lut #(
        .BEAT_W(BEAT_W), .TBL_ROWS(TBL_ROWS), .VREF_BITS(VREF_BITS),
        .AGG_COL(AGG_COL), .VIC_COL(VIC_COL), .VREF_MAP(VREF_MAP)
    ) u_run_lut (
        .sel(cap_sel), .half(cap_half), .idx(cnt), .word(run_word)
    );

    // Output register stage and done pulse after the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_valid <= 1'b0;
            seq_beat  <= '0;
            seq_word  <= '0;
            seq_done  <= 1'b0;
        end else begin
            seq_valid <= busy;
            seq_beat  <= cnt;
            seq_word  <= busy ? run_word : '0;
            seq_done  <= seq_valid && (seq_beat == LAST);
        end
    end

endmodule

// File: rtl/trn_pattern_gen_chk.sv
// Property checker for trn_pattern_gen, bound to every instance.
module trn_pattern_gen_chk #(
    parameter int BURST_LEN = 64,
    parameter int BEAT_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        pat_sel,
    input logic              half_bus,
    input logic [BEAT_W-1:0] beat_idx,
    input logic [31:0]       word,
    input logic              seq_valid,
    input logic [BEAT_W-1:0] seq_beat,
    input logic              seq_done
);

    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

    p_first_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_valid) |-> seq_beat == '0);

    p_beat_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_valid && $past(seq_valid)) |-> seq_beat == BEAT_W'($past(seq_beat) + 1'b1));

    p_done_place_r12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> ($past(seq_valid) && $past(seq_beat) == LAST));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    p_done_apart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !seq_valid);

    p_unknown_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_sel == 5'd7 || pat_sel >= 5'd20) |-> word == 32'h0);

    p_rl_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pat_sel == 5'd3 || pat_sel == 5'd4) &&
         (32'(beat_idx) < (half_bus ? 32'd3 : 32'd6))) |-> word == 32'h0);

    p_reset_clear_r14: assert property (@(posedge clk)
        !rst_n |=> (!seq_valid && !seq_done));

endmodule

bind trn_pattern_gen trn_pattern_gen_chk #(.BURST_LEN(BURST_LEN), .BEAT_W(BEAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .half_bus(half_bus),
    .beat_idx(beat_idx), .word(word), .seq_valid(seq_valid),
    .seq_beat(seq_beat), .seq_done(seq_done)
);

// File: tb/trn_pattern_gen_tb.sv
`timescale 1ns/1ps
module trn_pattern_gen_tb_top;

    localparam int          LEN  = 64;
    localparam int          BW   = 6;
    localparam logic [63:0] AGG  = 64'hA5C3_9E17_6B2D_F048;
    localparam logic [63:0] VIC  = 64'h3C5A_0FF1_92E4_7DB6;
    localparam logic [63:0] VMAP = 64'hD349_A71E_65BC_28F1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    pat_sel = '0;
    logic          half_bus = 1'b0;
    logic [BW-1:0] beat_idx = '0;
    logic [31:0]   word;
    logic          start = 1'b0;
    logic          seq_valid;
    logic [BW-1:0] seq_beat;
    logic [31:0]   seq_word;
    logic          seq_done;

    int checks = 0;
    int fails  = 0;
    int dones  = 0;
    bit prev_valid = 1'b0;
    logic [BW-1:0] prev_beat = '0;
    bit run_mon = 1'b0;

    logic [BW-1:0] q_beat[$];
    logic [31:0]   q_word[$];
    string         q_tag[$];

    always #2.5 clk = ~clk;

    trn_pattern_gen #(.BURST_LEN(LEN), .AGG_COL(AGG), .VIC_COL(VIC), .VREF_MAP(VMAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .half_bus(half_bus),
        .beat_idx(beat_idx), .word(word), .start(start),
        .seq_valid(seq_valid), .seq_beat(seq_beat), .seq_word(seq_word),
        .seq_done(seq_done)
    );

    function automatic logic [31:0] exp_word(int sel, bit half, int idx);
        logic [7:0] b0, b1, bb;
        int s, d;
        if (sel <= 1) begin
            if (half) return 32'h55AA55AA;
            return (idx == 0 || idx == 2 || idx == 5 || idx == 7) ? 32'h55555555 : 32'hAAAAAAAA;
        end
        if (sel == 2) return half ? 32'h55AA55AA : ((idx % 2 == 0) ? 32'h55555555 : 32'hAAAAAAAA);
        if (sel == 3 || sel == 4) begin
            if (idx < (half ? 3 : 6)) return 32'h0;
            return (sel == 3) ? 32'h80808080 : 32'h01010101;
        end
        if (sel == 5) begin
            if (half) return 32'h00FF00FF;
            bb = 8'(((64'hFF << (idx / 3)) >> 8) & 64'hFF);
            return {4{bb}};
        end
        if (sel == 6) begin
            if (half) return {{16{VIC[(2 * idx) % 64]}}, {16{VIC[(2 * idx + 1) % 64]}}};
            return VMAP[idx % 64] ? 32'hFFFFFFFF : 32'h0;
        end
        if (sel >= 8 && sel <= 15) begin
            d = sel - 8;
            for (int i = 0; i < 8; i++) begin
                bb[i] = (i == d) ? AGG[idx % 64] : VIC[idx % 64];
                b0[i] = (i == d) ? AGG[(2 * idx) % 64] : VIC[(2 * idx) % 64];
                b1[i] = (i == d) ? AGG[(2 * idx + 1) % 64] : VIC[(2 * idx + 1) % 64];
            end
            return half ? {b1, b1, b0, b0} : {4{bb}};
        end
        if (sel >= 16 && sel <= 19) begin
            s = sel - 16;
            if (half) begin
                if (s == 0) return 32'h0000FFFF;
                s = s - 1;
            end
            return ((idx / (s + 1)) % 2 == 1) ? 32'hFFFFFFFF : 32'h0;
        end
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic look(string tag, int sel, bit half, int idx);
        @(negedge clk);
        pat_sel = 5'(sel); half_bus = half; beat_idx = BW'(idx);
        #1;
        check($sformatf("%s sel=%0d half=%0d beat=%0d", tag, sel, half, idx),
              word, exp_word(sel, half, idx));
    endtask

    // Driver: queue the expected burst, then strobe start.
    task automatic burst(string tag, int sel, bit half);
        for (int b = 0; b < LEN; b++) begin
            q_beat.push_back(BW'(b));
            q_word.push_back(exp_word(sel, half, b));
            q_tag.push_back(tag);
        end
        @(negedge clk);
        pat_sel = 5'(sel); half_bus = half; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(int target);
        while (dones < target) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R13 queue drained after burst", 32'(q_word.size()), 32'h0);
    endtask

    // Monitor: pop and compare each valid beat, check done placement.
    always @(negedge clk) begin
        if (run_mon) begin
            if (seq_valid) begin
                if (q_word.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R13 extra beat actual=%0d expected=none", seq_beat);
                end else begin
                    check({q_tag[0], " R11 beat"}, 32'(seq_beat), 32'(q_beat[0]));
                    check({q_tag[0], " R11 word"}, seq_word, q_word[0]);
                    void'(q_beat.pop_front()); void'(q_word.pop_front()); void'(q_tag.pop_front());
                end
            end
            if (seq_done) begin
                dones++;
                check("R12 done after last beat", {31'h0, prev_valid && prev_beat == BW'(LEN - 1)}, 32'h1);
                check("R12 done apart from valid", {31'h0, seq_valid}, 32'h0);
            end
            prev_valid = seq_valid;
            prev_beat  = seq_beat;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R14 valid after reset", {31'h0, seq_valid}, 32'h0);
        check("R14 done after reset", {31'h0, seq_done}, 32'h0);
        check("R14 word after reset", seq_word, 32'h0);
        run_mon = 1'b1;

        // R1 alternating, 32-bit
        look("R1", 0, 0, 0); look("R1", 0, 0, 1); look("R1", 0, 0, 5);
        look("R1", 0, 0, 6); look("R1", 1, 0, 7); look("R1", 1, 0, 3);
        look("R1", 2, 0, 4); look("R1", 2, 0, 9);
        // R2 16-bit constants
        look("R2", 0, 1, 3); look("R2", 2, 1, 8); look("R2", 5, 1, 10);
        // R3 read-levelling thresholds
        look("R3", 3, 0, 5); look("R3", 3, 0, 6); look("R3", 3, 1, 2);
        look("R3", 3, 1, 3); look("R3", 4, 0, 6); look("R3", 4, 1, 2);
        // R4 crosstalk 32-bit, every lane
        for (int l = 0; l < 8; l++) begin
            look("R4", 8 + l, 0, 13); look("R4", 8 + l, 0, 40);
        end
        // R5 crosstalk 16-bit, with row wrap
        look("R5", 10, 1, 5); look("R5", 10, 1, 40); look("R5", 15, 1, 63);
        // R6 switching 32-bit
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 12; i++) look("R6", 16 + s, 0, i);
        // R7 switching 16-bit
        look("R7", 16, 1, 9);
        for (int i = 0; i < 4; i++) look("R7", 17, 1, i);
        look("R7", 19, 1, 7);
        // R8 reference bitmap
        for (int i = 0; i < 64; i++) look("R8", 6, 0, i);
        look("R8", 6, 1, 3); look("R8", 6, 1, 50);
        // R9 walking byte
        for (int i = 0; i < 64; i++) look("R9", 5, 0, i);
        // R10 unknown types
        look("R10", 7, 0, 4); look("R10", 20, 1, 9); look("R10", 31, 0, 63);

        // R11 bursts, R13 restart and type change mid-burst
        burst("R11 xt lane3", 11, 1'b0);
        repeat (10) @(negedge clk);
        pat_sel = 5'd18; half_bus = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        look("R13 lookup mid-burst", 1, 0, 2);
        wait_done(1);
        burst("R11 sso2 half", 18, 1'b1);
        wait_done(2);
        burst("R11 vref half", 6, 1'b1);
        wait_done(3);
        burst("R11 walk", 5, 1'b0);
        wait_done(4);
        check("R12 one done per burst", 32'(dones), 32'd4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule